// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine moves the data phase of a bus-master disk command. Once the device has entered its DMA data phase it is armed with a direction and a sector count. A start command then hands it the address of a descriptor table in memory. The engine reads descriptors one at a time. Each descriptor names a memory region, and the engine covers that region with memory bursts, none of which crosses a page boundary. It stops after the descriptor that carries the end flag.

Each descriptor is a 64-bit word. Bits 31:0 hold the region's start address, bits 47:32 its byte count, and bit 63 marks the last entry. A count of zero moves no data. All memory traffic goes through one request/acknowledge port. The port can refuse a request by raising busy, and the engine then backs off for a fixed time and tries again.

A byte budget equal to the commanded sector count times the sector size is charged for every burst. The engine finishes with a done pulse when the last descriptor has been served and the budget is empty. Any inconsistency or an abort ends it with an error pulse.

Top module: `prd_sg_dma`

## Requirements
- R1: After a start, descriptors are read as 8-byte memory reads (`we_o`=0, `len_o`=8) at the table base with its low three bits cleared, then at successive addresses 8 bytes apart. The descriptor layout is bits 31:0 start address, bits 47:32 byte count and bit 63 end flag.
- R2: A region is covered by bursts in address order. Each burst length is the remaining byte count, cut so that the burst ends exactly at the next page boundary (PAGE_BYTES, default 8192) when it would reach or pass that boundary.
- R3: While `busy_i` is high no request is issued. A refused request is retried only after at least BACKOFF cycles.
- R4: With `to_disk_i`=1 at arm time, data bursts are memory reads (`we_o`=0). With `to_disk_i`=0 they are memory writes (`we_o`=1).
- R5: The first data burst of a descriptor follows the descriptor's acknowledge by no fewer than DISK_LAT plus (byte count / SECTOR_BYTES) cycles.
- R6: A data burst longer than the remaining budget (sectors × SECTOR_BYTES, charged per burst) is not issued. The engine raises `err_o` and returns to idle.
- R7: After the end-flagged descriptor the engine pulses `done_o` if the budget is exactly zero, and pulses `err_o` otherwise. A descriptor without the end flag leads to the next descriptor read.
- R8: A start has effect only when the engine is armed. A start in idle issues no request.
- R9: An abort while armed or transferring pulses `err_o` one cycle later, returns to idle and stops all requests.
- R10: A data burst whose end would carry out of the ADDR_W-bit address space is not issued, and `err_o` is raised.
- R11: After reset the engine is idle, with `req_o`, `done_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enter the armed state (used only in idle) |
| to_disk_i | input | 1 | Direction latched at arm: 1 = data to disk |
| sectors_i | input | SEC_W | Sector count of the command, latched at arm |
| start_i | input | 1 | Start command (used only when armed) |
| table_base_i | input | ADDR_W | Descriptor table address, taken at start |
| abort_i | input | 1 | Abort the transfer |
| busy_i | input | 1 | Memory port cannot accept a request |
| req_o | output | 1 | Request issued this cycle |
| we_o | output | 1 | Request is a memory write |
| addr_o | output | ADDR_W | Request address |
| len_o | output | LEN_W | Request length in bytes |
| ack_i | input | 1 | Outstanding request completed |
| rdata_i | input | 64 | Descriptor word returned with ack_i |
| done_o | output | 1 | One-cycle pulse: transfer finished cleanly |
| err_o | output | 1 | One-cycle pulse: transfer ended in error |

## Verification
The checker assumes the memory port gives exactly one `ack_i` per issued request and no `ack_i` at other times. It also assumes the table base and descriptor addresses leave 8-byte reads inside a page. The bench memory model answers each recorded request once, two cycles later, and places every table at an 8-byte-aligned address. Busy windows are driven at the falling edge, so the rising edge sees the same busy value that the recorded `req_o` reflected.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_REQ, S_WAIT, S_LAT, S_BACKOFF
  } dma_state_e;

  localparam int DESC_BYTES = 8;
  localparam int DESC_CNT_LSB = 32;
  localparam int DESC_CNT_W = 16;
  localparam int DESC_EOT_BIT = 63;
endpackage

// File: rtl/prd_burst_calc.sv
module prd_burst_calc #(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int CNT_W = 16,
  localparam int PG_W = $clog2(PAGE_BYTES),
  localparam int LEN_W = PG_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              wrap_o
);
  localparam int CW = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [ADDR_W:0] page_end, sum;
  logic [ADDR_W:0] room_full;
  logic [CW-1:0]   room, rem_x;

  always_comb begin
    page_end  = {1'b0, addr_i[ADDR_W-1:PG_W], {PG_W{1'b0}}} + (ADDR_W+1)'(PAGE_BYTES);
    room_full = page_end - {1'b0, addr_i};
    room      = CW'(room_full[LEN_W-1:0]);
    rem_x     = CW'(rem_i);
    len_o     = (rem_x < room) ? LEN_W'(rem_x) : LEN_W'(room);
    sum       = {1'b0, addr_i} + (ADDR_W+1)'(len_o);
    wrap_o    = sum[ADDR_W];
  end
endmodule

// File: rtl/prd_wait_timer.sv
module prd_wait_timer #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prd_budget.sv
module prd_budget #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         sub_i,
  input  logic [W-1:0] amt_i,
  output logic         over_o,
  output logic         zero_after_o
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= val_i;
    else if (sub_i)  left_q <= left_q - amt_i;
  end

  assign over_o       = (amt_i > left_q);
  assign zero_after_o = (left_q == (sub_i ? amt_i : '0));
endmodule

// File: rtl/prd_sg_dma.sv
module prd_sg_dma
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int SEC_W = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int DISK_LAT = 4,
  parameter int BACKOFF = 8,
  localparam int LEN_W = $clog2(PAGE_BYTES) + 1,
  localparam int CNT_W = DESC_CNT_W,
  localparam int SB_W = $clog2(SECTOR_BYTES),
  localparam int BUD_W = SEC_W + SB_W + 1,
  localparam int TMR_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              to_disk_i,
  input  logic [SEC_W-1:0]  sectors_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic              abort_i,
  input  logic              busy_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  input  logic              ack_i,
  input  logic [63:0]       rdata_i,
  output logic              done_o,
  output logic              err_o
);
  dma_state_e        state_q;
  logic              fetch_q, dir_q, eot_q, done_q, err_q;
  logic [ADDR_W-1:0] ptr_q, cur_q;
  logic [CNT_W-1:0]  rem_q;

  logic [LEN_W-1:0]  blen;
  logic              wrap, over, bud_zero, data_err;
  logic [ADDR_W-1:0] d_base;
  logic [CNT_W-1:0]  d_cnt;
  logic              d_eot, got, fin, fin_eot;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  assign d_base = rdata_i[ADDR_W-1:0];
  assign d_cnt  = rdata_i[DESC_CNT_LSB +: DESC_CNT_W];
  assign d_eot  = rdata_i[DESC_EOT_BIT];

  prd_burst_calc #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_calc (
    .addr_i(cur_q), .rem_i(rem_q), .len_o(blen), .wrap_o(wrap)
  );

  prd_budget #(.W(BUD_W)) u_bud (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(state_q == S_IDLE && arm_i),
    .val_i(BUD_W'(sectors_i) << SB_W),
    .sub_i(got && !fetch_q),
    .amt_i(BUD_W'(blen)),
    .over_o(over), .zero_after_o(bud_zero)
  );

  assign got      = (state_q == S_WAIT) && ack_i;
  assign data_err = !fetch_q && (wrap || over);
  assign fin      = got && (fetch_q ? (d_cnt == '0) : (CNT_W'(blen) == rem_q));
  assign fin_eot  = fetch_q ? d_eot : eot_q;

  assign tmr_load = (got && fetch_q && d_cnt != '0) ||
                    (state_q == S_REQ && busy_i && !data_err);
  assign tmr_val  = (state_q == S_REQ) ? TMR_W'(BACKOFF - 1)
                                       : TMR_W'(DISK_LAT) + TMR_W'(d_cnt >> SB_W);

  prd_wait_timer #(.W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign req_o  = (state_q == S_REQ) && !busy_i && !data_err && !abort_i;
  assign we_o   = !fetch_q && !dir_q;
  assign addr_o = fetch_q ? ptr_q : cur_q;
  assign len_o  = fetch_q ? LEN_W'(DESC_BYTES) : blen;
  assign done_o = done_q;
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fetch_q <= 1'b0;
      dir_q   <= 1'b0;
      eot_q   <= 1'b0;
      ptr_q   <= '0;
      cur_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort_i && state_q != S_IDLE) begin
        state_q <= S_IDLE;
        err_q   <= 1'b1;
      end else begin
        unique case (state_q)
          S_IDLE: if (arm_i) begin
            state_q <= S_ARMED;
            dir_q   <= to_disk_i;
          end
          S_ARMED: if (start_i) begin
            state_q <= S_REQ;
            fetch_q <= 1'b1;
            ptr_q   <= {table_base_i[ADDR_W-1:3], 3'b000};
          end
          S_REQ: begin
            if (data_err) begin
              state_q <= S_IDLE;
              err_q   <= 1'b1;
            end else if (busy_i) state_q <= S_BACKOFF;
            else                 state_q <= S_WAIT;
          end
          S_WAIT: if (ack_i) begin
            if (fetch_q) begin
              ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
              cur_q <= d_base;
              rem_q <= d_cnt;
              eot_q <= d_eot;
            end else begin
              cur_q <= cur_q + ADDR_W'(blen);
              rem_q <= rem_q - CNT_W'(blen);
            end
            if (fin) begin
              if (fin_eot) begin
                state_q <= S_IDLE;
                done_q  <= bud_zero;
                err_q   <= !bud_zero;
              end else begin
                state_q <= S_REQ;
                fetch_q <= 1'b1;
              end
            end else if (fetch_q) begin
              state_q <= S_LAT;
              fetch_q <= 1'b0;
            end else begin
              state_q <= S_REQ;
            end
          end
          S_LAT, S_BACKOFF: if (tmr_zero) state_q <= S_REQ;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_sg_dma_chk.sv
module prd_sg_dma_chk
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int LEN_W = 14,
  parameter int BACKOFF = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input dma_state_e        st_i,
  input logic              busy_i,
  input logic              abort_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  logic [15:0] bo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bo_q <= '0;
    else if (st_i == S_BACKOFF) bo_q <= (bo_q == 16'hFFFF) ? bo_q : bo_q + 1'b1;
    else if (st_i != S_REQ)     bo_q <= '0;
  end

  AST_PAGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((LEN_W+1)'(addr_o[PG_W-1:0]) + (LEN_W+1)'(len_o) <= (LEN_W+1)'(PAGE_BYTES))); // R2
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> len_o != '0); // R2
  AST_BUSY_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_REQ && busy_i) |=> !req_o); // R3
  AST_BACKOFF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_REQ && bo_q != '0) |-> bo_q >= 16'(BACKOFF)); // R3
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_IDLE) |=> !req_o); // R8
  AST_ABORT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && st_i != S_IDLE) |=> (err_o && !req_o)); // R9
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R7
endmodule

bind prd_sg_dma prd_sg_dma_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .BACKOFF(BACKOFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(state_q), .busy_i(busy_i), .abort_i(abort_i),
  .req_o(req_o), .addr_o(addr_o), .len_o(len_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_prd_sg_dma.sv
module sim_prd_sg_dma;
  localparam int DISK_LAT = 4;
  localparam logic [31:0] TBASE = 32'h0F00_0000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic arm_i = 0, to_disk_i = 0, start_i = 0, abort_i = 0, busy_i = 0, ack_i = 0;
  logic [7:0]  sectors_i = '0;
  logic [31:0] table_base_i = '0;
  logic [63:0] rdata_i = '0;
  logic        req_o, we_o, done_o, err_o;
  logic [31:0] addr_o;
  logic [13:0] len_o;

  always #4 clk = ~clk;

  prd_sg_dma #(.DISK_LAT(DISK_LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .to_disk_i(to_disk_i), .sectors_i(sectors_i),
    .start_i(start_i), .table_base_i(table_base_i), .abort_i(abort_i), .busy_i(busy_i),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .len_o(len_o), .ack_i(ack_i),
    .rdata_i(rdata_i), .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [63:0] dtab [0:7];
  logic [31:0] b_addr [0:31];
  int          b_len  [0:31];
  logic        b_we   [0:31];
  logic [31:0] f_addr [0:7];
  int nb = 0, nf = 0, nreq = 0, done_seen = 0, err_seen = 0, busy_left = 0;
  int pend = 0, t_fack = 0, lat_meas = 0;
  bit pend_fetch = 0, lat_pend = 0, ended = 0;
  logic [63:0] pend_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    ack_i = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        ack_i = 1'b1; rdata_i = pend_rd;
        if (pend_fetch) begin t_fack = cyc; lat_pend = 1; end
      end
    end
    busy_i = (busy_left > 0);
    if (busy_left > 0) busy_left--;
    if (done_o) done_seen++;
    if (err_o) err_seen++;
    #1;
    if (req_o) begin
      nreq++;
      pend = 2;
      if (len_o == 14'd8 && !we_o && addr_o >= TBASE && addr_o < TBASE + 64) begin
        pend_fetch = 1; pend_rd = dtab[(addr_o - TBASE) >> 3];
        if (nf < 8) f_addr[nf] = addr_o;
        nf++;
      end else begin
        pend_fetch = 0; pend_rd = '0;
        if (lat_pend) begin lat_meas = cyc - t_fack; lat_pend = 0; end
        if (nb < 32) begin b_addr[nb] = addr_o; b_len[nb] = int'(len_o); b_we[nb] = we_o; end
        nb++;
      end
    end
  end

  function automatic logic [63:0] mkd(bit eot, logic [15:0] cnt, logic [31:0] base);
    return {eot, 15'd0, cnt, base};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    nb = 0; nf = 0; nreq = 0; done_seen = 0; err_seen = 0;
  endtask

  task automatic run(bit dir, logic [7:0] secs);
    clear_logs();
    @(negedge clk); arm_i = 1; to_disk_i = dir; sectors_i = secs;
    @(negedge clk); arm_i = 0; start_i = 1; table_base_i = TBASE;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < 3000 && done_seen == 0 && err_seen == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_o == 0 && done_o == 0 && err_o == 0, "R11 reset outputs", {req_o, done_o, err_o}, 0);
  endtask

  task automatic t_single();
    dtab[0] = mkd(1, 16'd1024, 32'h0000_2000);
    run(1'b1, 8'd2);
    chk(nf == 1 && f_addr[0] == TBASE, "R1 fetch at base", f_addr[0], TBASE);
    chk(nb == 1 && b_addr[0] == 32'h2000 && b_len[0] == 1024, "R2 single burst", b_len[0], 1024);
    chk(b_we[0] == 1'b0, "R4 to-disk is memory read", b_we[0], 0);
    chk(done_seen == 1 && err_seen == 0, "R7 done on empty budget", done_seen, 1);
    chk(lat_meas >= DISK_LAT + 2 && lat_meas <= DISK_LAT + 4, "R5 latency 2 sectors", lat_meas, DISK_LAT + 2);
  endtask

  task automatic t_cross();
    dtab[0] = mkd(1, 16'd1024, 32'h0000_3E00);
    run(1'b0, 8'd2);
    chk(nb == 2, "R2 split count", nb, 2);
    chk(b_addr[0] == 32'h3E00 && b_len[0] == 'h200, "R2 first piece to boundary", b_len[0], 'h200);
    chk(b_addr[1] == 32'h4000 && b_len[1] == 'h200, "R2 second piece", b_addr[1], 'h4000);
    chk(b_we[0] == 1'b1 && b_we[1] == 1'b1, "R4 from-disk is memory write", b_we[0], 1);
    chk(done_seen == 1, "R7 done after split", done_seen, 1);
  endtask

  task automatic t_multi();
    dtab[0] = mkd(0, 16'h0200, 32'h0000_8000);
    dtab[1] = mkd(1, 16'h2200, 32'h0000_A100);
    run(1'b1, 8'd18);
    chk(nf == 2 && f_addr[1] == TBASE + 8, "R1 pointer advances 8", f_addr[1], TBASE + 8);
    chk(nb == 3 && b_addr[1] == 32'hA100 && b_len[1] == 'h1F00, "R2 cut at page end", b_len[1], 'h1F00);
    chk(b_addr[2] == 32'hC000 && b_len[2] == 'h300, "R2 tail after boundary", b_len[2], 'h300);
    chk(done_seen == 1 && err_seen == 0, "R7 chained descriptors done", done_seen, 1);
    chk(lat_meas >= DISK_LAT + 17 && lat_meas <= DISK_LAT + 19, "R5 latency 17 sectors", lat_meas, DISK_LAT + 17);
  endtask

  task automatic t_budget();
    dtab[0] = mkd(1, 16'd1024, 32'h0000_2000);
    run(1'b1, 8'd1);
    chk(nb == 0 && err_seen == 1 && done_seen == 0, "R6 over-budget burst refused", nb, 0);
    run(1'b1, 8'd3);
    chk(nb == 1 && err_seen == 1 && done_seen == 0, "R7 leftover budget is error", err_seen, 1);
  endtask

  task automatic t_wrap();
    dtab[0] = mkd(1, 16'h1000, 32'hFFFF_F000);
    run(1'b1, 8'd8);
    chk(nb == 0 && err_seen == 1, "R10 wrap refused", nb, 0);
  endtask

  task automatic t_start_idle();
    clear_logs();
    @(negedge clk); start_i = 1; table_base_i = TBASE;
    @(negedge clk); start_i = 0;
    repeat (30) @(negedge clk);
    chk(nreq == 0 && err_seen == 0, "R8 start in idle ignored", nreq, 0);
  endtask

  task automatic t_abort();
    int n0;
    clear_logs();
    @(negedge clk); arm_i = 1; sectors_i = 8'd2;
    @(negedge clk); arm_i = 0; abort_i = 1;
    @(negedge clk); abort_i = 0;
    repeat (2) @(negedge clk);
    chk(err_seen == 1, "R9 abort while armed", err_seen, 1);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (20) @(negedge clk);
    chk(nreq == 0, "R8 start after abort ignored", nreq, 0);
    dtab[0] = mkd(1, 16'd1024, 32'h0000_2000);
    clear_logs();
    @(negedge clk); arm_i = 1; to_disk_i = 1;
    @(negedge clk); arm_i = 0; start_i = 1; table_base_i = TBASE;
    @(negedge clk); start_i = 0;
    repeat (6) @(negedge clk);
    abort_i = 1;
    @(negedge clk); abort_i = 0;
    n0 = nreq;
    repeat (40) @(negedge clk);
    chk(err_seen == 1 && nreq == n0 && done_seen == 0, "R9 abort mid-transfer", nreq, n0);
  endtask

  task automatic t_busy();
    dtab[0] = mkd(1, 16'd1024, 32'h0000_3E00);
    busy_left = 25;
    run(1'b1, 8'd2);
    chk(nb == 2 && b_addr[1] == 32'h4000 && done_seen == 1, "R3 retried after busy", nb, 2);
    busy_left = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) dtab[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_idle();
    t_single();
    t_cross();
    t_multi();
    t_budget();
    t_wrap();
    t_abort();
    t_busy();
    finish_run();
  end
endmodule